// File: doc/BRIEF.md
# Fixed-Latency Frame Verdict Trigger

This block sits at the end of a byte-per-clock header-checking chain. For each frame it gathers the pass pulses from the link-layer, network-layer and transport-layer checkers, along with a partially reduced checksum. It then issues one keep/discard decision a constant number of cycles after the header ends. The decision never depends on frame contents for its timing, so downstream logic can line the verdict up with a payload delay line of fixed depth.

An accept needs every check to have explicitly passed within the current frame. A check that did not report by the header-end strobe counts as failed. A frame that ends before its header completed still receives a reject, timed from its end marker. The final checksum reduction runs in two registered steps, separate from the decision gate. All per-frame state clears when the frame ends, so consecutive frames cannot influence each other.

Top module: `frame_verdict_trigger`

## Requirements
- R1: While rst_ni is low, and after reset until a frame triggers a verdict, verdict_valid_o stays low.
- R2: A frame's first hdr_done_i high in cycle k gives verdict_valid_o high for exactly one cycle, cycle k+LATENCY (LATENCY >= 2, default 4).
- R3: verdict_accept_o is high in the verdict cycle only if eth_pass_i, ip_pass_i, udp_pass_i and cs_vld_i were each seen high at least once between frame start and the hdr_done_i cycle inclusive, and the checksum passes per R5.
- R4: If any of the three pass pulses or the checksum strobe is missing, the verdict is a reject (verdict_valid_o high, verdict_accept_o low). verdict_accept_o is never high without verdict_valid_o.
- R5: The checksum passes when the most recent cs_sum_i (32 bits) folded to 16 bits with end-around carry, high half plus low half and then the carry added back, equals 16'hFFFF. A sum of zero fails.
- R6: frame_end_i high in cycle k with no hdr_done_i in the frame so far gives a reject verdict in cycle k+LATENCY. hdr_done_i and frame_end_i in the same cycle give exactly one verdict.
- R7: After hdr_done_i, any further pass pulses, checksum strobes and hdr_done_i pulses in the same frame are ignored: no extra verdict is produced and the next frame is not affected.
- R8: A frame starts in the cycle after frame_end_i. No flag or checksum carries across, so a frame with no pass pulses is rejected even right after an accepted one.
- R9: Frames whose hdr_done_i pulses fall in consecutive cycles each get their own verdict, in order, with no interference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| hdr_done_i | input | 1 | Header of the current frame is complete |
| frame_end_i | input | 1 | Last byte of the current frame |
| eth_pass_i | input | 1 | Link-layer header check passed |
| ip_pass_i | input | 1 | Network-layer header check passed |
| udp_pass_i | input | 1 | Transport-layer header check passed |
| cs_vld_i | input | 1 | cs_sum_i carries a partial checksum |
| cs_sum_i | input | 32 | Partially reduced checksum sum |
| verdict_valid_o | output | 1 | One-cycle verdict strobe |
| verdict_accept_o | output | 1 | Verdict is keep (valid only with the strobe) |

## Verification
The bench runs fold corner sums, including all-ones, swapped halves, a carry that wraps back to 16'hFFFF, a carry that lands on 16'h0001 and zero. A design that folds only once, or treats zero as valid, would accept or reject the wrong one of these. It drops each check in turn and also runs an aborted frame. A decision gate that is not fully qualified would accept those, and abort handling done wrong would lose the reject or mistime it. It sends late passes, a repeated header strobe and back-to-back single-cycle frames. Per-frame state that leaked between frames, or a shared pipeline slot, would show as a spurious accept, an extra verdict or a verdict in the wrong cycle.

// File: rtl/vt_pkg.sv
`timescale 1ns/1ps
package vt_pkg;
  parameter int unsigned SUM_W = 32;
  localparam int unsigned CS_W = SUM_W / 2;

  // snapshot taken at the trigger cycle
  typedef struct packed {
    logic             vld;
    logic             eth;
    logic             ip;
    logic             udp;
    logic             cs_seen;
    logic [SUM_W-1:0] sum;
  } cand_t;

  // after first fold step
  typedef struct packed {
    logic          vld;
    logic          eth;
    logic          ip;
    logic          udp;
    logic          cs_seen;
    logic [CS_W:0] part;
  } part_t;

  // fully qualified, ready for the decision gate
  typedef struct packed {
    logic vld;
    logic eth;
    logic ip;
    logic udp;
    logic cs_ok;
  } chk_t;
endpackage

// File: rtl/vt_frame_latch.sv
`timescale 1ns/1ps
module vt_frame_latch
  import vt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_done_i,
  input  logic             frame_end_i,
  input  logic             eth_pass_i,
  input  logic             ip_pass_i,
  input  logic             udp_pass_i,
  input  logic             cs_vld_i,
  input  logic [SUM_W-1:0] cs_sum_i,
  output cand_t            cand_o
);
  logic             hdr_seen_q;
  logic             eth_q, ip_q, udp_q, cs_q;
  logic [SUM_W-1:0] sum_q;
  logic             open_w, good_w;

  assign open_w = !hdr_seen_q;
  // only a completed header may carry pass flags; an abort is forced to fail
  assign good_w = open_w && hdr_done_i;

  always_comb begin
    cand_o.vld     = open_w && (hdr_done_i || frame_end_i);
    cand_o.eth     = good_w && (eth_q || eth_pass_i);
    cand_o.ip      = good_w && (ip_q  || ip_pass_i);
    cand_o.udp     = good_w && (udp_q || udp_pass_i);
    cand_o.cs_seen = good_w && (cs_q  || cs_vld_i);
    cand_o.sum     = cs_vld_i ? cs_sum_i : sum_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_seen_q <= 1'b0;
      eth_q      <= 1'b0;
      ip_q       <= 1'b0;
      udp_q      <= 1'b0;
      cs_q       <= 1'b0;
      sum_q      <= '0;
    end else if (frame_end_i) begin
      hdr_seen_q <= 1'b0;
      eth_q      <= 1'b0;
      ip_q       <= 1'b0;
      udp_q      <= 1'b0;
      cs_q       <= 1'b0;
      sum_q      <= '0;
    end else if (good_w) begin
      hdr_seen_q <= 1'b1;
      eth_q      <= 1'b0;
      ip_q       <= 1'b0;
      udp_q      <= 1'b0;
      cs_q       <= 1'b0;
      sum_q      <= '0;
    end else if (open_w) begin
      eth_q <= eth_q || eth_pass_i;
      ip_q  <= ip_q  || ip_pass_i;
      udp_q <= udp_q || udp_pass_i;
      if (cs_vld_i) begin
        cs_q  <= 1'b1;
        sum_q <= cs_sum_i;
      end
    end
  end
endmodule

// File: rtl/vt_csum_fold.sv
`timescale 1ns/1ps
module vt_csum_fold
  import vt_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  cand_t cand_i,
  output chk_t  chk_o
);
  part_t         part_d, part_q;
  logic [CS_W-1:0] fold_w;
  chk_t          chk_d, chk_q;

  always_comb begin
    part_d.vld     = cand_i.vld;
    part_d.eth     = cand_i.eth;
    part_d.ip      = cand_i.ip;
    part_d.udp     = cand_i.udp;
    part_d.cs_seen = cand_i.cs_seen;
    part_d.part    = {1'b0, cand_i.sum[CS_W-1:0]} + {1'b0, cand_i.sum[SUM_W-1:CS_W]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) part_q <= '0;
    else         part_q <= part_d;
  end

  // end-around carry; cannot overflow again
  assign fold_w = part_q.part[CS_W-1:0] + {{(CS_W-1){1'b0}}, part_q.part[CS_W]};

  always_comb begin
    chk_d.vld   = part_q.vld;
    chk_d.eth   = part_q.eth;
    chk_d.ip    = part_q.ip;
    chk_d.udp   = part_q.udp;
    chk_d.cs_ok = part_q.cs_seen && (fold_w == {CS_W{1'b1}});
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_q <= '0;
    else         chk_q <= chk_d;
  end

  assign chk_o = chk_q;
endmodule

// File: rtl/vt_delay_line.sv
`timescale 1ns/1ps
module vt_delay_line
  import vt_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  chk_t chk_i,
  output chk_t chk_o
);
  if (DEPTH == 0) begin : g_pass
    assign chk_o = chk_i;
  end else begin : g_pipe
    chk_t pipe_q [DEPTH];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int k = 0; k < DEPTH; k++) pipe_q[k] <= '0;
      end else begin
        pipe_q[0] <= chk_i;
        for (int k = 1; k < DEPTH; k++) pipe_q[k] <= pipe_q[k-1];
      end
    end
    assign chk_o = pipe_q[DEPTH-1];
  end
endmodule

// File: rtl/frame_verdict_trigger.sv
`timescale 1ns/1ps
module frame_verdict_trigger
  import vt_pkg::*;
#(
  parameter int unsigned LATENCY = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hdr_done_i,
  input  logic             frame_end_i,
  input  logic             eth_pass_i,
  input  logic             ip_pass_i,
  input  logic             udp_pass_i,
  input  logic             cs_vld_i,
  input  logic [SUM_W-1:0] cs_sum_i,
  output logic             verdict_valid_o,
  output logic             verdict_accept_o
);
  localparam int unsigned FOLD_STAGES = 2;
  localparam int unsigned ALIGN_DEPTH = LATENCY - FOLD_STAGES;

  if (LATENCY < FOLD_STAGES) begin : g_bad_latency
    $error("LATENCY must be at least 2");
  end

  cand_t cand_w;
  chk_t  chk_w, tail_w;

  vt_frame_latch u_latch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hdr_done_i  (hdr_done_i),
    .frame_end_i (frame_end_i),
    .eth_pass_i  (eth_pass_i),
    .ip_pass_i   (ip_pass_i),
    .udp_pass_i  (udp_pass_i),
    .cs_vld_i    (cs_vld_i),
    .cs_sum_i    (cs_sum_i),
    .cand_o      (cand_w)
  );

  vt_csum_fold u_fold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cand_i (cand_w),
    .chk_o  (chk_w)
  );

  vt_delay_line #(.DEPTH(ALIGN_DEPTH)) u_align (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .chk_i  (chk_w),
    .chk_o  (tail_w)
  );

  // decision gate: registered bits only
  assign verdict_valid_o  = tail_w.vld;
  assign verdict_accept_o = tail_w.vld && tail_w.eth && tail_w.ip && tail_w.udp && tail_w.cs_ok;
endmodule

// File: rtl/vt_trigger_chk.sv
`timescale 1ns/1ps
module vt_trigger_chk
  import vt_pkg::*;
#(
  parameter int unsigned LATENCY = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hdr_done_i,
  input logic             frame_end_i,
  input logic             eth_pass_i,
  input logic             ip_pass_i,
  input logic             udp_pass_i,
  input logic             cs_vld_i,
  input logic [SUM_W-1:0] cs_sum_i,
  input logic             verdict_valid_o,
  input logic             verdict_accept_o
);
  localparam logic [SUM_W-1:0] FOLD_MOD = SUM_W'((64'd1 << CS_W) - 1);

  logic             hs_q, e_q, i_q, u_q, c_q;
  logic [SUM_W-1:0] s_q, s_now;
  logic             trig_m, ok_m, abort_m;
  logic [LATENCY-1:0] trig_h, ok_h, abort_h;

  assign s_now   = cs_vld_i ? cs_sum_i : s_q;
  assign trig_m  = !hs_q && (hdr_done_i || frame_end_i);
  assign abort_m = !hs_q && frame_end_i && !hdr_done_i;
  // ones-complement fold gives all ones iff nonzero multiple of 2^CS_W-1
  assign ok_m    = !hs_q && hdr_done_i && (e_q || eth_pass_i) && (i_q || ip_pass_i) &&
                   (u_q || udp_pass_i) && (c_q || cs_vld_i) &&
                   (s_now != '0) && ((s_now % FOLD_MOD) == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {hs_q, e_q, i_q, u_q, c_q} <= '0;
      s_q     <= '0;
      trig_h  <= '0;
      ok_h    <= '0;
      abort_h <= '0;
    end else begin
      trig_h  <= {trig_h[LATENCY-2:0], trig_m};
      ok_h    <= {ok_h[LATENCY-2:0], ok_m};
      abort_h <= {abort_h[LATENCY-2:0], abort_m};
      if (frame_end_i || (!hs_q && hdr_done_i)) begin
        hs_q <= !frame_end_i;
        {e_q, i_q, u_q, c_q} <= '0;
        s_q <= '0;
      end else if (!hs_q) begin
        e_q <= e_q || eth_pass_i;
        i_q <= i_q || ip_pass_i;
        u_q <= u_q || udp_pass_i;
        if (cs_vld_i) begin
          c_q <= 1'b1;
          s_q <= cs_sum_i;
        end
      end
    end
  end

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o == trig_h[LATENCY-1]);

  p_accept_match_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_valid_o |-> (verdict_accept_o == ok_h[LATENCY-1]));

  p_no_bad_accept_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verdict_accept_o |-> verdict_valid_o);

  p_abort_reject_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_h[LATENCY-1] |-> (verdict_valid_o && !verdict_accept_o));
endmodule

bind frame_verdict_trigger vt_trigger_chk #(.LATENCY(LATENCY)) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .hdr_done_i       (hdr_done_i),
  .frame_end_i      (frame_end_i),
  .eth_pass_i       (eth_pass_i),
  .ip_pass_i        (ip_pass_i),
  .udp_pass_i       (udp_pass_i),
  .cs_vld_i         (cs_vld_i),
  .cs_sum_i         (cs_sum_i),
  .verdict_valid_o  (verdict_valid_o),
  .verdict_accept_o (verdict_accept_o)
);

// File: tb/frame_verdict_trigger_bench.sv
`timescale 1ns/1ps
module frame_verdict_trigger_bench;
  localparam int LAT = 4;
  localparam int NV  = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        hdr_done_i = 1'b0, frame_end_i = 1'b0;
  logic        eth_pass_i = 1'b0, ip_pass_i = 1'b0, udp_pass_i = 1'b0;
  logic        cs_vld_i = 1'b0;
  logic [31:0] cs_sum_i = '0;
  logic        verdict_valid_o, verdict_accept_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit    exp_acc [int];
  string exp_tag [int];

  // {eth, ip, udp, cs_vld, sum, expected accept}
  localparam logic [36:0] VEC [NV] = '{
    {4'b1111, 32'h0000_FFFF, 1'b1},  // R3 plain accept
    {4'b1111, 32'hFFFF_0000, 1'b1},  // R5 halves swapped
    {4'b1111, 32'h0001_FFFE, 1'b1},  // R5 one fold
    {4'b1111, 32'hFFFF_FFFF, 1'b1},  // R5 carry wraps
    {4'b1111, 32'h0001_FFFF, 1'b0},  // R5 wraps to 0001
    {4'b1111, 32'h0000_0000, 1'b0},  // R5 zero fails
    {4'b0111, 32'h0000_FFFF, 1'b0},  // R4 no eth
    {4'b1011, 32'h0000_FFFF, 1'b0},  // R4 no ip
    {4'b1101, 32'h0000_FFFF, 1'b0},  // R4 no udp
    {4'b1110, 32'h0000_FFFF, 1'b0}   // R4 no checksum
  };

  frame_verdict_trigger #(.LATENCY(LAT)) u_frame_verdict_trigger (
    .clk_i            (clk_i),
    .rst_ni           (rst_ni),
    .hdr_done_i       (hdr_done_i),
    .frame_end_i      (frame_end_i),
    .eth_pass_i       (eth_pass_i),
    .ip_pass_i        (ip_pass_i),
    .udp_pass_i       (udp_pass_i),
    .cs_vld_i         (cs_vld_i),
    .cs_sum_i         (cs_sum_i),
    .verdict_valid_o  (verdict_valid_o),
    .verdict_accept_o (verdict_accept_o)
  );

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic step(input logic h, input logic f, input logic [3:0] flg, input logic [31:0] s);
    @(negedge clk_i);
    hdr_done_i  = h;
    frame_end_i = f;
    {eth_pass_i, ip_pass_i, udp_pass_i, cs_vld_i} = flg;
    cs_sum_i    = s;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 4'b0000, 32'h0);
  endtask

  task automatic expect_here(input bit acc, input string tag);
    exp_acc[cyc + LAT] = acc;
    exp_tag[cyc + LAT] = tag;
  endtask

  // verdict monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (exp_acc.exists(cyc)) begin
        checks++;
        if (verdict_valid_o !== 1'b1 || verdict_accept_o !== exp_acc[cyc]) begin
          errors++;
          $display("FAIL %s cycle %0d: valid=%b accept=%b expected valid=1 accept=%b",
                   exp_tag[cyc], cyc, verdict_valid_o, verdict_accept_o, exp_acc[cyc]);
        end
        exp_acc.delete(cyc);
        exp_tag.delete(cyc);
      end else if (verdict_valid_o !== 1'b0) begin
        checks++;
        errors++;
        $display("FAIL R2/R7 cycle %0d: unexpected valid=%b expected 0", cyc, verdict_valid_o);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++;
    if (verdict_valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: valid=%b expected 0", verdict_valid_o);
    end
    rst_ni = 1'b1;
    idle(3);
    checks++;
    if (verdict_valid_o !== 1'b0 || verdict_accept_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset: valid=%b accept=%b expected 0 0", verdict_valid_o, verdict_accept_o);
    end

    // table walk: flags, header end, frame end, gap
    for (int v = 0; v < NV; v++) begin
      step(1'b0, 1'b0, VEC[v][36:33], VEC[v][32:1]);
      step(1'b1, 1'b0, 4'b0000, 32'h0);
      expect_here(VEC[v][0], $sformatf("R2/R3/R4/R5 vec%0d", v));
      step(1'b0, 1'b1, 4'b0000, 32'h0);
      idle(2);
    end
    idle(LAT + 1);

    // R3: flags arriving in the header-end cycle still count
    step(1'b1, 1'b1, 4'b1111, 32'h0000_FFFF);
    expect_here(1'b1, "R3 same-cycle flags");
    idle(LAT + 1);

    // R5: latest checksum wins
    step(1'b0, 1'b0, 4'b1111, 32'h0000_0001);
    step(1'b0, 1'b0, 4'b0001, 32'h8000_7FFF);
    step(1'b1, 1'b1, 4'b0000, 32'h0);
    expect_here(1'b1, "R5 latest sum");
    idle(LAT + 1);

    // R6: abort before header end, all flags present
    step(1'b0, 1'b0, 4'b1111, 32'h0000_FFFF);
    step(1'b0, 1'b1, 4'b0000, 32'h0);
    expect_here(1'b0, "R6 abort");
    idle(LAT + 1);

    // R7: late flags and repeated header end ignored
    step(1'b1, 1'b0, 4'b0000, 32'h0);
    expect_here(1'b0, "R7 header without flags");
    step(1'b0, 1'b0, 4'b1111, 32'h0000_FFFF);
    step(1'b1, 1'b0, 4'b1111, 32'h0000_FFFF);
    step(1'b0, 1'b1, 4'b0000, 32'h0);
    idle(1);
    step(1'b1, 1'b1, 4'b0000, 32'h0);
    expect_here(1'b0, "R7 late flags leaked");
    idle(LAT + 1);

    // R8: accepted frame then empty frame
    step(1'b1, 1'b1, 4'b1111, 32'hFFFF_0000);
    expect_here(1'b1, "R8 first frame");
    step(1'b0, 1'b0, 4'b0000, 32'h0);
    step(1'b1, 1'b1, 4'b0000, 32'h0);
    expect_here(1'b0, "R8 carried state");
    idle(LAT + 1);

    // R9: single-cycle frames back to back
    step(1'b1, 1'b1, 4'b1111, 32'h0000_FFFF);
    expect_here(1'b1, "R9 frame a");
    step(1'b1, 1'b1, 4'b0000, 32'h0000_FFFF);
    expect_here(1'b0, "R9 frame b");
    step(1'b1, 1'b1, 4'b1111, 32'hFFFF_FFFF);
    expect_here(1'b1, "R9 frame c");
    step(1'b1, 1'b1, 4'b1101, 32'h0000_FFFF);
    expect_here(1'b0, "R9 frame d");
    idle(LAT + 3);

    foreach (exp_acc[k]) begin
      checks++;
      errors++;
      $display("FAIL %s: no verdict at cycle %0d, expected accept=%b", exp_tag[k], k, exp_acc[k]);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule